// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core

This block is a 32-bit processor core that completes every instruction in one clock cycle. It implements a seven-instruction load/store subset. The subset covers register add and subtract, OR with a zero-extended immediate, word load and word store with a signed offset, branch when two registers are equal, and an absolute jump. The core holds its own program counter, next-address logic, a 32-entry register file, an ALU with a zero flag, an immediate extender and a stateless decoder. Instruction memory and data memory are small internal word arrays.

Programs enter instruction memory through a valid/ready load stream while the core sits in reset. `ld_ready` is high exactly while `rst` is high, and a word is stored on a rising edge where `ld_valid && ld_ready`. The stream has no other back-pressure, so a producer must present each word with `ld_valid` and hold it until a clock edge that sees `ld_ready`. Words offered outside reset are dropped. Once reset is released the core fetches from address 0. Two combinational debug read ports expose any register and any data-memory word.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high `rst` clears the PC to 0 on the next rising edge. `ld_ready` equals `rst`. A load word is written to instruction-word `ld_addr` only on an edge where `ld_valid && ld_ready`; otherwise instruction memory is unchanged.
- R2: Opcode 000000 is register-type. Funct 100000 writes rs+rt and funct 100010 writes rs−rt into the register at bits 15:11. rs is at bits 25:21, rt at bits 20:16 and funct at bits 5:0.
- R3: Opcode 001101 writes rs OR the zero-extended bits 15:0 into the register at bits 20:16.
- R4: Opcode 100011 loads the data word at byte address rs + sign-extended bits 15:0 into register rt. Opcode 101011 stores rt at that address. Memory is word-addressed by address bits above bit 1.
- R5: Opcode 000100, when rs equals rt, sets the next PC to PC+4 plus the sign-extended bits 15:0 shifted left by 2. Otherwise the next PC is PC+4.
- R6: Opcode 000010 sets the next PC to the top 4 bits of PC+4, then bits 25:0, then two zero bits.
- R7: Register 0 always reads as 0, and writes that target it change nothing. A written register reads back the new value from the next cycle.
- R8: Any other opcode, and any register-type funct other than the two above, writes neither register nor memory and advances the PC by 4.
- R9: Every instruction other than a taken branch or a jump advances the PC by exactly 4 per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load stream word valid |
| ld_ready | output | 1 | Load stream ready (high during reset) |
| ld_addr | input | IAW | Instruction word index to load |
| ld_data | input | 32 | Instruction word to load |
| pc_o | output | 32 | Current program counter (byte address) |
| dbg_reg_sel | input | 5 | Register index for debug read |
| dbg_reg_val | output | 32 | Value of selected register |
| dbg_mem_sel | input | DAW | Data-memory word index for debug read |
| dbg_mem_val | output | 32 | Value of selected data word |

## Verification
A wrong decode or a wrong next-address result shows on `pc_o` at the very next rising edge, because every instruction retires in one cycle. A per-cycle PC trace therefore pins a control fault to a single instruction. A wrong operand, extension or write-back appears in a register or data word one cycle later. It stays there, because the program never overwrites its results, and the debug ports read it back after the program settles into its final self-loop. The trace also proves that skipped instructions never ran, because the registers they would have corrupted still hold their earlier values.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XW = 32;
  localparam int NREG = 32;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_ORI   = 6'b001101;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_J     = 6'b000010;
  localparam logic [5:0] FN_ADD   = 6'b100000;
  localparam logic [5:0] FN_SUB   = 6'b100010;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_OR  = 2'd2
  } alu_op_e;

  typedef struct packed {
    logic    dst_rd;
    logic    b_imm;
    logic    wb_mem;
    logic    reg_we;
    logic    mem_we;
    logic    is_branch;
    logic    is_jump;
    logic    imm_signed;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.alu_op = ALU_ADD;
    unique case (opcode)
      OP_RTYPE: begin
        if (funct == FN_ADD || funct == FN_SUB) begin
          ctrl.dst_rd = 1'b1;
          ctrl.reg_we = 1'b1;
          ctrl.alu_op = (funct == FN_SUB) ? ALU_SUB : ALU_ADD;
        end
      end
      OP_ORI: begin
        ctrl.b_imm  = 1'b1;
        ctrl.reg_we = 1'b1;
        ctrl.alu_op = ALU_OR;
      end
      OP_LW: begin
        ctrl.b_imm      = 1'b1;
        ctrl.imm_signed = 1'b1;
        ctrl.wb_mem     = 1'b1;
        ctrl.reg_we     = 1'b1;
      end
      OP_SW: begin
        ctrl.b_imm      = 1'b1;
        ctrl.imm_signed = 1'b1;
        ctrl.mem_we     = 1'b1;
      end
      OP_BEQ: begin
        ctrl.is_branch = 1'b1;
        ctrl.alu_op    = ALU_SUB;
      end
      OP_J: ctrl.is_jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = XW
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    unique case (op)
      ALU_SUB: y = a - b;
      ALU_OR:  y = a | b;
      default: y = a + b;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int NR = 32,
  parameter int W  = 32,
  localparam int AW = $clog2(NR)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  input  logic [AW-1:0] ra3,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  output logic [W-1:0]  rd3
);
  logic [W-1:0] regs [NR];

  always_ff @(posedge clk) begin
    if (we && wa != '0) regs[wa] <= wd;
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
  assign rd3 = (ra3 == '0) ? '0 : regs[ra3];

  // R7: a register written on one edge reads back the new value next cycle
  a_r7_write_readback: assert property (@(posedge clk) disable iff (rst)
    ($past(we) && $past(wa) != '0 && ra1 == $past(wa)) |-> rd1 == $past(wd));
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS),
  localparam int RAW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ld_valid,
  output logic           ld_ready,
  input  logic [IAW-1:0] ld_addr,
  input  logic [XW-1:0]  ld_data,
  output logic [XW-1:0]  pc_o,
  input  logic [RAW-1:0] dbg_reg_sel,
  output logic [XW-1:0]  dbg_reg_val,
  input  logic [DAW-1:0] dbg_mem_sel,
  output logic [XW-1:0]  dbg_mem_val
);
  logic [XW-1:0] imem [IMEM_WORDS];
  logic [XW-1:0] dmem [DMEM_WORDS];
  logic [XW-1:0] pc, pc_plus4, br_target, jmp_target, pc_next;
  logic [XW-1:0] instr, imm_ext, imm_sext, rs_v, rt_v, alu_b, alu_y, mem_rd, wb_v;
  logic [RAW-1:0] wa;
  logic          alu_zero, take_br;
  ctrl_t         ctrl;

  // instruction load stream, accepted only during reset
  assign ld_ready = rst;
  always_ff @(posedge clk) begin
    if (ld_valid && ld_ready) imem[ld_addr] <= ld_data;
  end

  assign instr = imem[pc[IAW+1:2]];

  sc_decode u_dec (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctrl   (ctrl)
  );

  assign imm_sext = {{16{instr[15]}}, instr[15:0]};
  assign imm_ext  = ctrl.imm_signed ? imm_sext : {16'b0, instr[15:0]};
  assign wa       = ctrl.dst_rd ? instr[15:11] : instr[20:16];

  sc_regfile #(.NR(NREG), .W(XW)) u_rf (
    .clk (clk),
    .rst (rst),
    .we  (ctrl.reg_we && !rst),
    .wa  (wa),
    .wd  (wb_v),
    .ra1 (instr[25:21]),
    .ra2 (instr[20:16]),
    .ra3 (dbg_reg_sel),
    .rd1 (rs_v),
    .rd2 (rt_v),
    .rd3 (dbg_reg_val)
  );

  assign alu_b = ctrl.b_imm ? imm_ext : rt_v;

  sc_alu #(.W(XW)) u_alu (
    .a    (rs_v),
    .b    (alu_b),
    .op   (ctrl.alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // data memory: word index from address bits above bit 1
  always_ff @(posedge clk) begin
    if (ctrl.mem_we && !rst) dmem[alu_y[DAW+1:2]] <= rt_v;
  end
  assign mem_rd      = dmem[alu_y[DAW+1:2]];
  assign dbg_mem_val = dmem[dbg_mem_sel];
  assign wb_v        = ctrl.wb_mem ? mem_rd : alu_y;

  // next-address logic
  assign pc_plus4   = pc + 32'd4;
  assign br_target  = pc_plus4 + {imm_sext[29:0], 2'b00};
  assign jmp_target = {pc_plus4[31:28], instr[25:0], 2'b00};
  assign take_br    = ctrl.is_branch && alu_zero;
  always_comb begin
    if (ctrl.is_jump)  pc_next = jmp_target;
    else if (take_br)  pc_next = br_target;
    else               pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end
  assign pc_o = pc;

  // R1: first cycle out of reset starts at address 0
  a_r1_pc_zero: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> pc == '0);
  // R9: sequential flow steps by one word
  a_r9_pc_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ctrl.is_jump) && !$past(ctrl.is_branch && rs_v == rt_v))
      |-> pc == $past(pc) + 32'd4);
  // R5: equal operands on a branch redirect to the offset target
  a_r5_branch_target: assert property (@(posedge clk) disable iff (rst)
    (ctrl.is_branch && rs_v == rt_v) |=> pc == $past(br_target));
  // R6: jump keeps the region bits and loads the word index
  a_r6_jump_low: assert property (@(posedge clk) disable iff (rst)
    ctrl.is_jump |=> pc[27:0] == {$past(instr[25:0]), 2'b00});
endmodule

// File: tb/sc_core_tb.sv
module sc_core_tb;
  localparam int IMEM_WORDS = 64;
  localparam int DMEM_WORDS = 64;
  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);
  localparam int NTRACE = 21;
  localparam int NREGCHK = 11;

  // expected PC after i rising edges out of reset
  localparam logic [31:0] PC_TRACE [NTRACE] = '{
    32'd0, 32'd4, 32'd8, 32'd12, 32'd16, 32'd20, 32'd24, 32'd28,
    32'd32, 32'd36, 32'd40, 32'd44, 32'd48, 32'd52, 32'd56, 32'd60,
    32'd64, 32'd76, 32'd80, 32'd92, 32'd92};
  // {register index, expected value}
  localparam logic [36:0] REG_CHK [NREGCHK] = '{
    {5'd0,  32'h0000_0000}, {5'd1, 32'h0000_8005}, {5'd2, 32'h0000_0003},
    {5'd3,  32'h0000_8008}, {5'd4, 32'hFFFF_7FFE}, {5'd5, 32'h0000_0010},
    {5'd6,  32'h0000_8008}, {5'd7, 32'h0000_0077}, {5'd8, 32'h0000_0088},
    {5'd9,  32'h0000_0099}, {5'd10, 32'h0000_00AA}};

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           ld_valid = 1'b0;
  logic           ld_ready;
  logic [IAW-1:0] ld_addr = '0;
  logic [31:0]    ld_data = '0;
  logic [31:0]    pc_o;
  logic [4:0]     dbg_reg_sel = '0;
  logic [31:0]    dbg_reg_val;
  logic [DAW-1:0] dbg_mem_sel = '0;
  logic [31:0]    dbg_mem_val;
  logic [31:0]    prog [IMEM_WORDS];
  int             total = 0;
  int             bad = 0;

  always #4 clk = ~clk;

  sc_core #(.IMEM_WORDS(IMEM_WORDS), .DMEM_WORDS(DMEM_WORDS)) u_dut (
    .clk (clk), .rst (rst), .ld_valid (ld_valid), .ld_ready (ld_ready),
    .ld_addr (ld_addr), .ld_data (ld_data), .pc_o (pc_o),
    .dbg_reg_sel (dbg_reg_sel), .dbg_reg_val (dbg_reg_val),
    .dbg_mem_sel (dbg_mem_sel), .dbg_mem_val (dbg_mem_val)
  );

  function automatic logic [31:0] rt_ins(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'b000000, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction
  function automatic logic [31:0] it_ins(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, rs[4:0], rt[4:0], imm};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    for (int w = 0; w < IMEM_WORDS; w++) prog[w] = 32'h0;
    prog[0]  = it_ins(6'b001101, 0, 1, 16'h8005);    // ori r1 (R3 zero-extend)
    prog[1]  = it_ins(6'b001101, 0, 2, 16'h0003);
    prog[2]  = rt_ins(1, 2, 3, 6'b100000);           // add r3 (R2)
    prog[3]  = rt_ins(2, 1, 4, 6'b100010);           // sub r4 (R2)
    prog[4]  = it_ins(6'b101011, 0, 3, 16'h0008);    // sw r3 -> word 2 (R4)
    prog[5]  = it_ins(6'b001101, 0, 5, 16'h0010);
    prog[6]  = it_ins(6'b101011, 5, 4, 16'hFFFC);    // sw r4 -> word 3 (R4)
    prog[7]  = it_ins(6'b100011, 5, 6, 16'hFFF8);    // lw r6 <- word 2 (R4)
    prog[8]  = it_ins(6'b001101, 0, 0, 16'h1234);    // R7 write to r0
    prog[9]  = rt_ins(1, 2, 0, 6'b100000);           // R7 write to r0
    prog[10] = it_ins(6'b001101, 0, 7, 16'h0077);
    prog[11] = rt_ins(1, 2, 7, 6'b100100);           // R8 bad funct
    prog[12] = it_ins(6'b111111, 1, 7, 16'h0001);    // R8 bad opcode
    prog[13] = it_ins(6'b001101, 0, 8, 16'h0088);
    prog[14] = it_ins(6'b001101, 0, 10, 16'h00AA);
    prog[15] = it_ins(6'b000100, 1, 2, 16'h0005);    // R5 not taken
    prog[16] = it_ins(6'b000100, 3, 6, 16'h0002);    // R5 taken -> 19
    prog[17] = it_ins(6'b001101, 0, 8, 16'h0BAD);
    prog[18] = it_ins(6'b001101, 0, 8, 16'h0BAD);
    prog[19] = it_ins(6'b001101, 0, 9, 16'h0099);
    prog[20] = {6'b000010, 26'd23};                  // R6 jump -> 23
    prog[21] = it_ins(6'b001101, 0, 10, 16'h0BAD);
    prog[22] = it_ins(6'b001101, 0, 10, 16'h0BAD);
    prog[23] = it_ins(6'b000100, 0, 0, 16'hFFFF);    // self-loop

    repeat (2) @(negedge clk);
    #1;
    chk("R1 pc in reset", pc_o, 32'h0);
    chk("R1 ready in reset", {31'b0, ld_ready}, 32'h1);
    for (int w = 0; w < IMEM_WORDS; w++) begin
      @(negedge clk);
      ld_valid = 1'b1;
      ld_addr  = w[IAW-1:0];
      ld_data  = prog[w];
    end
    @(negedge clk);
    ld_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;

    // PC trace: R2..R6, R8, R9
    for (int i = 0; i < NTRACE; i++) begin
      #1;
      chk($sformatf("R9/R5/R6/R8 pc trace step %0d", i), pc_o, PC_TRACE[i]);
      @(negedge clk);
    end
    repeat (4) @(negedge clk);

    for (int i = 0; i < NREGCHK; i++) begin
      dbg_reg_sel = REG_CHK[i][36:32];
      #1;
      chk($sformatf("R2/R3/R4/R7/R8 reg %0d", REG_CHK[i][36:32]), dbg_reg_val, REG_CHK[i][31:0]);
    end
    dbg_mem_sel = DAW'(2);
    #1;
    chk("R4 mem word 2", dbg_mem_val, 32'h0000_8008);
    dbg_mem_sel = DAW'(3);
    #1;
    chk("R4 mem word 3", dbg_mem_val, 32'hFFFF_7FFE);

    // R1: load offered outside reset is dropped; loop word stays intact
    chk("R1 ready low out of reset", {31'b0, ld_ready}, 32'h0);
    @(negedge clk);
    ld_valid = 1'b1;
    ld_addr  = IAW'(23);
    ld_data  = it_ins(6'b001101, 0, 11, 16'h0011);
    @(negedge clk);
    ld_valid = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 load ignored, pc still looping", pc_o, 32'd92);

    // R1: mid-run reset returns PC to zero
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 reset clears pc", pc_o, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule